// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

This block is a cycle-accurate model of a synchronous static RAM that takes a new read or write on every clock edge. When the bus changes direction no idle cycle is needed. The address, the command, three chip selects and per-lane write enables are registered on the rising edge. Write data follows its command two enabled edges later. Read data comes out of an output register and occupies the same bus slot that write data would use. Because of this, any mix of reads and writes can run back to back. A write that is still in flight is forwarded to a read of the same word, so a read always sees the newest data.

Each command either loads a fresh external address or continues the current burst. A continue cycle reuses the read or write type chosen when the burst was loaded. It steps the two low address bits in linear order or in exclusive-or order, and a separate address generator produces those bits. A hold input freezes the whole pipeline for one edge, and the output register freezes with it. A doze input turns the bus off and makes every edge ignored while the array keeps its contents. An output-enable input gates the read drivers asynchronously.

Top module: `zt_sram`

## Requirements
- R1: While rst_n is low at a rising edge, no command is captured, and after that edge q_drive is 0. The first enabled edge after reset carries no earlier operation.
- R2: A read loaded at enabled edge E puts the word of its address on q, with q_drive high, after the next enabled edge E+1. Both stay there until the enabled edge after that.
- R3: A write loaded at enabled edge E stores the value present on d at the second enabled edge after E (E+2).
- R4: lane_wr_n is active low. Bit i enables the write of lane i, which is d bits [9i+8:9i]. Lanes whose bit is 1 keep their old content. A write with every bit at 1 changes nothing and leaves q_drive low in its slot.
- R5: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and each read returns the correct word.
- R6: A read loaded one edge after a write to the same address returns that write's data, merged lane by lane with the stored word, although the array has not yet been updated when the read is issued.
- R7: A load cycle (start_n=0) with cs_a_n=1, cs_b_n=1 or cs_c=0 is a deselect, and q_drive stays low in its slot. On continue cycles (start_n=1) the chip selects are ignored.
- R8: On a continue cycle, wr_n is ignored and the burst keeps the type chosen at its load. The address keeps its upper bits while its two low bits step from the loaded value b: with burst_xor=0 the k-th access uses b+k mod 4, and with burst_xor=1 it uses b XOR k.
- R9: A continue cycle that follows a deselect is also a deselect. It does not read, does not write, and q_drive stays low.
- R10: An edge with hold=1 changes nothing: no write happens, q and q_drive keep their values (driven after a read slot, off after a write slot), and the pipeline resumes on the next edge with hold=0.
- R11: drv_en_n=1 forces q_drive low at once without touching the pipeline, and drv_en_n=0 restores the read output at once. q_drive is low in write slots for either level of drv_en_n.
- R12: While doze=1, q_drive is low and every edge is ignored as under hold, so writes presented during doze do not reach the array. When doze falls, the held state comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| hold | input | 1 | High: ignore this edge, freeze all stages |
| doze | input | 1 | High: ignore edges and turn the bus off, contents kept |
| cs_a_n | input | 1 | Chip select, active low, sampled on load cycles |
| cs_b_n | input | 1 | Second chip select, active low, sampled on load cycles |
| cs_c | input | 1 | Third chip select, active high, sampled on load cycles |
| start_n | input | 1 | Low: load a new address and command; high: continue the burst |
| wr_n | input | 1 | Command type on load cycles: 0 write, 1 read |
| burst_xor | input | 1 | Burst order: 0 linear, 1 exclusive-or |
| lane_wr_n | input | LANES | Per-lane write enables, active low, given with the command |
| addr | input | ADDR_W | Word address |
| d | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| drv_en_n | input | 1 | Asynchronous active-low gate on the read drivers |
| q | output | LANES*LANE_W | Read data (zero when not driven) |
| q_drive | output | 1 | High while q is actively driven onto the bus |

## Verification
The assertions assume that rst_n is held low for at least one edge before any command. They also assume that addr, the command inputs and d are settled at each rising edge, and that doze and drv_en_n change only away from the edge. The bench keeps to this by changing every input at the falling edge and by starting with several reset edges. It reads only addresses it has already written, so no read returns an undefined word.

// File: rtl/zt_sram_pkg.sv
// Package: types shared by the pipelined SRAM model.
// Assumes: nothing; holds only the command encoding carried down the pipeline.
package zt_sram_pkg;

    // Operation held in each pipeline stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_burst_addr.sv
// Module: zt_burst_addr
// Produces the address of the current cycle. On a load cycle it passes the
// external address through. On a continue cycle it keeps the upper bits of the
// loaded address and steps the low BURST_W bits linearly or by exclusive-or.
// Assumes: ADDR_W > BURST_W; step is high only on edges the pipeline accepts.
module zt_burst_addr #(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic              xor_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low_bits;

    // Low address bits of a continue cycle in the selected order.
    always_comb begin
        if (xor_order) begin
            low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        end else begin
            low_bits = base_q[BURST_W-1:0] + cnt_q;
        end
    end

    // Address used by the command of this cycle.
    always_comb begin
        if (load) begin
            cur_addr = ext_addr;
        end else begin
            cur_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
        end
    end

    // Latch the burst base on loads and count beats on continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            if (load) begin
                base_q <= ext_addr;
                cnt_q  <= BURST_W'(1);
            end else begin
                cnt_q  <= cnt_q + BURST_W'(1);
            end
        end
    end

    // R10: an ignored edge leaves the burst position untouched.
    p_burst_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(base_q) && $stable(cnt_q)))
        else $error("burst state moved on an ignored edge");

endmodule

// File: rtl/zt_cmd_stage.sv
// Module: zt_cmd_stage
// Decodes the command of each accepted edge and carries it through two
// pipeline stages: stage 1 is the cycle after capture (read data leaves the
// array here), stage 2 is the data slot (write data is taken here).
// Assumes: en is low on every edge that must be ignored (hold or doze).
module zt_cmd_stage
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 2,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_n,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] cur_addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_lane_n
);

    op_e              next_op;
    logic [LANES-1:0] s1_lane_n;

    // Command type: chosen on loads, inherited from the burst on continues.
    always_comb begin
        if (!start_n) begin
            if (!sel_ok) begin
                next_op = OP_IDLE;
            end else if (wr_n) begin
                next_op = OP_READ;
            end else begin
                next_op = OP_WRITE;
            end
        end else begin
            next_op = s1_op;
        end
    end

    // Shift the command through both stages on every accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op     <= OP_IDLE;
            s1_addr   <= '0;
            s1_lane_n <= '1;
            s2_op     <= OP_IDLE;
            s2_addr   <= '0;
            s2_lane_n <= '1;
        end else if (en) begin
            s1_op     <= next_op;
            s1_addr   <= cur_addr;
            s1_lane_n <= lane_wr_n;
            s2_op     <= s1_op;
            s2_addr   <= s1_addr;
            s2_lane_n <= s1_lane_n;
        end
    end

    // R7: a load with any select inactive enters a bubble.
    p_desel_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_n && !sel_ok) |=> (s1_op == OP_IDLE))
        else $error("deselected load did not enter a bubble");

    // R9: continuing after a deselect stays deselected.
    p_cont_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_n && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE))
        else $error("continue after deselect started an access");

    // R8: a continue keeps the burst type and the upper address bits.
    p_burst_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_n) |=> ((s1_op == $past(s1_op)) &&
                             (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W]))))
        else $error("continue changed burst type or upper address");

    // R10: an ignored edge freezes both stages.
    p_stage_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)))
        else $error("pipeline stage moved on an ignored edge");

    // R3: the data slot always holds what stage 1 held one accepted edge before.
    p_slot_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (s2_op == $past(s1_op)))
        else $error("data slot lost its command");

endmodule

// File: rtl/zt_store.sv
// Module: zt_store
// Storage array with per-lane writes in the data slot, read-after-write
// forwarding from the write data port, and the read output register.
// Assumes: s1_* and s2_* come from zt_cmd_stage; d is valid on accepted edges
// whose stage-2 command is a write.
module zt_store
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  op_e                     s1_op,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  op_e                     s2_op,
    input  logic [ADDR_W-1:0]       s2_addr,
    input  logic [LANES-1:0]        s2_lane_n,
    input  logic [LANES*LANE_W-1:0] d,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic                    rd_vld
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic              same_word;
    logic              commit;

    assign commit    = en && (s2_op == OP_WRITE);
    assign same_word = commit && (s2_addr == s1_addr);

    // Stored word of the stage-1 read, overlaid by the write landing this edge.
    always_comb begin
        rd_word = mem[s1_addr];
        for (int i = 0; i < LANES; i++) begin
            if (same_word && !s2_lane_n[i]) begin
                rd_word[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
            end
        end
    end

    // Commit the enabled lanes of the data-slot write into the array.
    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            for (int i = 0; i < LANES; i++) begin
                if (!s2_lane_n[i]) begin
                    mem[s2_addr][i*LANE_W +: LANE_W] <= d[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Output register: loaded for reads, marked empty for other slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            rd_vld <= 1'b0;
        end else if (en) begin
            rd_vld <= (s1_op == OP_READ);
            if (s1_op == OP_READ) begin
                rd_q <= rd_word;
            end
        end
    end

    // R10: the output register holds through an ignored edge.
    p_out_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rd_q) && $stable(rd_vld)))
        else $error("output register moved on an ignored edge");

    // R11: a write slot never drives read data.
    p_write_slot_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s1_op != OP_READ) |=> !rd_vld)
        else $error("non-read slot marked read data valid");

    // R6: a same-word read behind a full write returns the written data.
    p_forward_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (same_word && s1_op == OP_READ && s2_lane_n == '0) |=> (rd_q == $past(d)))
        else $error("forwarded read missed in-flight write data");

endmodule

// File: rtl/zt_sram.sv
// Module: zt_sram (top)
// Pipelined synchronous SRAM model with zero turnaround between reads and
// writes. It ties together the burst address generator, the command pipeline
// and the storage array, and applies the asynchronous bus gates.
// Assumes: ADDR_W > BURST_W; inputs settle before each rising edge.
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    doze,
    input  logic                    cs_a_n,
    input  logic                    cs_b_n,
    input  logic                    cs_c,
    input  logic                    start_n,
    input  logic                    wr_n,
    input  logic                    burst_xor,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] d,
    input  logic                    drv_en_n,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel_ok;
    logic [ADDR_W-1:0] cur_addr;
    op_e               s1_op;
    op_e               s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    logic [DATA_W-1:0] rd_q;
    logic              rd_vld;

    // Edge acceptance and chip-select decode.
    assign en     = !hold && !doze;
    assign sel_ok = !cs_a_n && !cs_b_n && cs_c;

    zt_burst_addr #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (en),
        .load      (!start_n),
        .xor_order (burst_xor),
        .ext_addr  (addr),
        .cur_addr  (cur_addr)
    );

    zt_cmd_stage #(
        .ADDR_W  (ADDR_W),
        .LANES   (LANES),
        .BURST_W (BURST_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .start_n   (start_n),
        .sel_ok    (sel_ok),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .cur_addr  (cur_addr),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s2_op     (s2_op),
        .s2_addr   (s2_addr),
        .s2_lane_n (s2_lane_n)
    );

    zt_store #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s2_op     (s2_op),
        .s2_addr   (s2_addr),
        .s2_lane_n (s2_lane_n),
        .d         (d),
        .rd_q      (rd_q),
        .rd_vld    (rd_vld)
    );

    // Asynchronous bus gating by output enable and doze.
    always_comb begin
        q_drive = rd_vld && !drv_en_n && !doze;
        q       = q_drive ? rd_q : '0;
    end

    // R1: the cycle after a reset edge never drives the bus.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rd_vld)
        else $error("read data valid right after reset");

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/100ps
module zt_sram_test;

    localparam int AW = 4;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    localparam logic [DW-1:0] D1 = 18'h12345;
    localparam logic [DW-1:0] D2 = 18'h2ABCD;
    localparam logic [DW-1:0] D3 = 18'h155AA;
    localparam logic [DW-1:0] D4 = 18'h3C0F1;
    localparam logic [DW-1:0] D5 = 18'h0F0F0;
    localparam logic [DW-1:0] MG = (D2 & 18'h3FE00) | (D3 & 18'h001FF);
    localparam logic [DW-1:0] V0 = 18'h0A001;
    localparam logic [DW-1:0] V1 = 18'h1B002;
    localparam logic [DW-1:0] V2 = 18'h2C003;
    localparam logic [DW-1:0] V3 = 18'h3D004;
    localparam logic [DW-1:0] VW = 18'h15A5A;

    // Row: start_n, sel_ok, wr_n, lane_wr_n[2], addr[4], d[18], exp_drive, exp_q[18]
    localparam int NROW = 14;
    localparam logic [45:0] TBL [NROW] = '{
        {1'b0, 1'b1, 1'b0, 2'b00, 4'h1, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b1, 1'b0, 2'b00, 4'h2, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'h1, D1,    1'b0, 18'h0},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'h2, D2,    1'b1, D1},
        {1'b0, 1'b1, 1'b0, 2'b10, 4'h2, 18'h0, 1'b1, D2},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'h2, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b1, 1'b0, 2'b00, 4'h3, D3,    1'b1, MG},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'h3, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b0, 1'b1, 2'b11, 4'h0, D4,    1'b1, D4},
        {1'b0, 1'b1, 1'b0, 2'b11, 4'h3, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'h3, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b0, 1'b1, 2'b11, 4'h0, D5,    1'b1, D4},
        {1'b0, 1'b0, 1'b1, 2'b11, 4'h0, 18'h0, 1'b0, 18'h0},
        {1'b0, 1'b0, 1'b1, 2'b11, 4'h0, 18'h0, 1'b0, 18'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hold, doze, cs_a_n, cs_b_n, cs_c, start_n, wr_n, burst_xor, drv_en_n;
    logic [NL-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d;
    logic [DW-1:0] q;
    logic          q_drive;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .doze(doze),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c),
        .start_n(start_n), .wr_n(wr_n), .burst_xor(burst_xor),
        .lane_wr_n(lane_wr_n), .addr(addr), .d(d), .drv_en_n(drv_en_n),
        .q(q), .q_drive(q_drive)
    );

    // Compare the bus against an expected drive level and word.
    task automatic chk(input string tag, input logic eo, input logic [DW-1:0] ed);
        checks++;
        if (q_drive !== eo || (eo && q !== ed)) begin
            fails++;
            $display("FAIL %s: actual drive=%b q=%h expected drive=%b q=%h",
                     tag, q_drive, q, eo, ed);
        end
    endtask

    // One enabled-or-held edge: drive inputs, pass the edge, return at negedge.
    task automatic cyc(input logic an, input logic bn, input logic c, input logic ld,
                       input logic wn, input logic [NL-1:0] be, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        cs_a_n = an; cs_b_n = bn; cs_c = c; start_n = ld; wr_n = wn;
        lane_wr_n = be; addr = a; d = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, a, '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] be, input logic [DW-1:0] wd);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, be, a, wd);
    endtask

    task automatic desel(input logic [DW-1:0] wd);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, '0, wd);
    endtask

    task automatic cont(input logic wn, input logic [DW-1:0] wd);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, wn, 2'b00, '0, wd);
    endtask

    function automatic string row_tag(input int i);
        case (i)
            3, 4:    return "R2/R3";
            6:       return "R4/R6";
            8:       return "R6";
            11:      return "R4 abort";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hold = 1'b0; doze = 1'b0; drv_en_n = 1'b0; burst_xor = 1'b0;
        cs_a_n = 1'b0; cs_b_n = 1'b0; cs_c = 1'b1; start_n = 1'b0; wr_n = 1'b1;
        lane_wr_n = '1; addr = '0; d = '0;
        @(negedge clk);
        // R1: reads presented during reset are not captured.
        rd(4'h0); rd(4'h0); rd(4'h0);
        chk("R1 in reset", 1'b0, '0);
        rst_n = 1'b1;
        desel('0);
        chk("R1 first edge after reset", 1'b0, '0);
        desel('0);

        // Vector table: alternating reads and writes, lanes, forwarding, abort.
        for (int i = 0; i < NROW; i++) begin
            cyc(~TBL[i][44], 1'b0, 1'b1, TBL[i][45], TBL[i][43], TBL[i][42:41],
                TBL[i][40:37], TBL[i][36:19]);
            chk($sformatf("%s row %0d", row_tag(i), i), TBL[i][18], TBL[i][17:0]);
        end

        // R8: linear write burst from address 6 (6,7,4,5), wr_n ignored on continues.
        burst_xor = 1'b0;
        wr(4'h6, 2'b00, '0);
        cont(1'b1, '0);
        cont(1'b1, V0);
        cont(1'b1, V1);
        desel(V2);
        desel(V3);
        rd(4'h4);
        rd(4'h5);
        chk("R8 linear beat 3 at addr 4", 1'b1, V2);
        rd(4'h6);
        chk("R8 linear beat 4 at addr 5", 1'b1, V3);
        rd(4'h7);
        chk("R8 linear beat 1 at addr 6", 1'b1, V0);
        desel('0);
        chk("R8 linear beat 2 at addr 7", 1'b1, V1);
        desel('0);

        // R8: xor-order read burst from address 5 (5,4,7,6), wr_n=0 ignored.
        burst_xor = 1'b1;
        rd(4'h5);
        cont(1'b0, '0);
        chk("R8 xor beat addr 5", 1'b1, V3);
        cont(1'b0, '0);
        chk("R8 xor beat addr 4", 1'b1, V2);
        cont(1'b0, '0);
        chk("R8 xor beat addr 7", 1'b1, V1);
        desel('0);
        chk("R8 xor beat addr 6", 1'b1, V0);
        desel('0);
        chk("R8 after burst", 1'b0, '0);
        burst_xor = 1'b0;

        // R9: continues after a deselect neither drive nor write.
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'h6, 18'h3FFFF);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4'h0, 18'h3FFFF);
        chk("R9 continue deselect 1", 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4'h0, 18'h3FFFF);
        chk("R9 continue deselect 2", 1'b0, '0);
        desel(18'h3FFFF);
        chk("R9 continue deselect 3", 1'b0, '0);
        desel(18'h3FFFF);
        rd(4'h7);
        desel('0);
        chk("R9 addr 7 unchanged", 1'b1, V1);

        // R7: each chip select alone deselects a load.
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 4'h6, '0);
        desel('0);
        chk("R7 cs_a_n high", 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'h6, '0);
        desel('0);
        chk("R7 cs_b_n high", 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 4'h6, '0);
        desel('0);
        chk("R7 cs_c low", 1'b0, '0);
        // R7: selects are ignored on a continue cycle.
        rd(4'h4);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 4'h0, '0);
        chk("R7 burst beat 1", 1'b1, V2);
        desel('0);
        chk("R7 continue with selects off", 1'b1, V3);
        desel('0);

        // R10: hold during a read slot keeps the bus driven, no write taken.
        rd(4'h6);
        desel('0);
        chk("R10 read before hold", 1'b1, V0);
        hold = 1'b1;
        wr(4'h6, 2'b00, '0);
        chk("R10 hold edge 1", 1'b1, V0);
        wr(4'h6, 2'b00, '0);
        chk("R10 hold edge 2", 1'b1, V0);
        hold = 1'b0;
        desel('0);
        chk("R10 resume", 1'b0, '0);
        // R10: hold during a write slot keeps the bus off and delays the data.
        wr(4'h7, 2'b00, '0);
        desel('0);
        hold = 1'b1;
        desel(18'h3FFFF);
        chk("R10 hold in write slot", 1'b0, '0);
        desel(18'h3FFFF);
        hold = 1'b0;
        desel(VW);
        rd(4'h7);
        desel('0);
        chk("R10 write data after hold", 1'b1, VW);
        desel('0);

        // R11: output enable gates the drivers asynchronously.
        drv_en_n = 1'b1;
        rd(4'h6);
        desel('0);
        chk("R11 gated off", 1'b0, '0);
        drv_en_n = 1'b0;
        #1;
        chk("R11 gate reopened", 1'b1, V0);
        wr(4'h5, 2'b11, '0);
        desel('0);
        chk("R11 write slot off", 1'b0, '0);
        desel('0);

        // R12: doze turns the bus off and ignores edges.
        rd(4'h6);
        desel('0);
        chk("R12 before doze", 1'b1, V0);
        doze = 1'b1;
        #1;
        chk("R12 doze bus off", 1'b0, '0);
        wr(4'h6, 2'b00, '0);
        wr(4'h6, 2'b00, '0);
        wr(4'h6, 2'b00, '0);
        chk("R12 doze edges", 1'b0, '0);
        doze = 1'b0;
        cs_a_n = 1'b1; start_n = 1'b0;
        #1;
        chk("R12 state back after doze", 1'b1, V0);
        desel('0);
        desel('0);
        rd(4'h6);
        desel('0);
        chk("R12 contents kept", 1'b1, V0);

        // R1: reset mid-run clears a driven bus.
        rst_n = 1'b0;
        desel('0);
        chk("R1 reset clears bus", 1'b0, '0);
        rst_n = 1'b1;
        desel('0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule